// File: doc/BRIEF.md
# Program Memory Data Window Mapper

This block sits on an 8-bit data-space bus and lets a processor read constant bytes that live in a 4K-byte program memory. Data-space locations 0x40 to 0x7F act as a read-only window; a six-bit page register chooses which 64-byte slice of program memory the window shows. The program-memory address is the page register on top and the low six data-address bits below.

The page register answers to data address 0xC9 and can only be written. Reading it returns 0xFF, a single-bit operation aimed at it is refused, and its contents survive reset. Software therefore has to write it before the first window read, and the block raises a flag when that has not happened since reset. Writes into the window are dropped and flagged. Every other address goes straight through to a RAM port. Program memory and RAM both return data one clock after the strobe.

Control is a four-state machine that records which kind of read was launched on the last cycle. S_IDLE means no read is pending. S_WIN means a window read is pending and data comes from program memory. S_RAM means a RAM read is pending. S_LOCK means a read of the page register is pending and the answer is 0xFF. The transition on every clock is set by the strobe then present, from any state. A read in the window goes to S_WIN. A read of 0xC9 goes to S_LOCK. Any other read goes to S_RAM. No read at all goes to S_IDLE.

Top module: `pmem_window_map`

## Requirements
- R1: A read strobe at data address 0x40..0x7F asserts `pm_rd` in the same cycle. One clock later the block drives `rd_valid` high with `bus_rdata` equal to the program-memory byte, and the RAM port stays idle.
- R2: The program-memory address is {page[5:0], bus_addr[5:0]}. With page 0x28, a read of 0x59 fetches 0xA19. With page 0x00, a read of 0x40 fetches 0x000. With page 0x3F, a read of 0x7F fetches 0xFFF.
- R3: A write strobe at 0xC9 stores `bus_wdata[5:0]` in the page register. Bits [7:6] of the written byte have no effect.
- R4: A read of 0xC9 returns 0xFF with `rd_valid` one clock later and pulses `illegal_write` in that same cycle. The page register is unaffected.
- R5: A bit-operation strobe at 0xC9 is rejected: the page register keeps its value and `illegal_write` pulses one clock later.
- R6: A write or bit-operation strobe at 0x40..0x7F writes nothing (`ram_wr` stays low) and pulses `illegal_write` for one cycle, one clock later.
- R7: Reset does not change the page register.
- R8: `window_uninit` is high, alongside `rd_valid`, for a window read made when no page write has occurred since reset. It is low for window reads after a page write.
- R9: A read at any other address asserts `ram_rd` with `ram_addr` = `bus_addr`. One clock later `bus_rdata` equals `ram_rdata` and `rd_valid` is high.
- R10: During reset and in the first cycle after it, `rd_valid`, `illegal_write` and `window_uninit` are low.
- R11: A write or bit-operation strobe at any other address asserts `ram_wr` with `ram_wdata` = `bus_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Data-space address |
| bus_wdata | input | 8 | Write data (whole modified byte for bit operations) |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Byte write strobe |
| bus_bitop | input | 1 | Single-bit set/clear write-back strobe |
| bus_rdata | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one clock after bus_rd |
| window_uninit | output | 1 | Window read made before any page write |
| illegal_write | output | 1 | One-cycle pulse for a refused access |
| pm_addr | output | 12 | Program-memory address |
| pm_rd | output | 1 | Program-memory read enable |
| pm_rdata | input | 8 | Program-memory data, one clock after pm_rd |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rd | output | 1 | RAM read enable |
| ram_wr | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM data, one clock after ram_rd |

## Verification
The bench writes the page with bits [7:6] set. A design that kept those bits, or swapped the two halves of the address, fetches the wrong byte at 0xA19, 0x000 or 0xFFF. A bit operation aimed at 0xC9 and a write into the window are each followed by a window read. A design that accepted either would show a moved page or a corrupted RAM byte. The bench also resets after a page write and checks that the same page still reads back while `window_uninit` rises, which catches a design that clears the page or does not clear the flag. A read of 0xC9 has to answer 0xFF and not the stored page.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
    localparam int DATA_W   = 8;
    localparam int PAGE_W   = 6;
    localparam int OFF_W    = 6;
    localparam int PM_AW    = PAGE_W + OFF_W;
    localparam logic [DATA_W-1:0] WIN_BASE  = 8'h40;
    localparam logic [DATA_W-1:0] PAGE_ADDR = 8'hC9;
    localparam logic [DATA_W-1:0] LOCK_DATA = 8'hFF;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WIN  = 2'd1,
        S_RAM  = 2'd2,
        S_LOCK = 2'd3
    } rd_state_t;
endpackage

// File: rtl/pmw_decode.sv
module pmw_decode
    import pmw_pkg::*;
(
    input  logic [DATA_W-1:0] addr,
    output logic              in_win,
    output logic              is_page,
    output logic              is_plain
);
    localparam int WIN_SPAN = 1 << OFF_W;

    always_comb begin
        in_win   = (addr >= WIN_BASE) && (addr < (WIN_BASE + DATA_W'(WIN_SPAN)));
        is_page  = (addr == PAGE_ADDR);
        is_plain = !in_win && !is_page;
    end
endmodule

// File: rtl/pmw_page_reg.sv
module pmw_page_reg
    import pmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PAGE_W-1:0] wdata,
    output logic [PAGE_W-1:0] page,
    output logic              written
);
    // page contents deliberately carry no reset
    always_ff @(posedge clk) begin
        if (we) page <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  written <= 1'b0;
        else if (we) written <= 1'b1;
    end
endmodule

// File: rtl/pmem_window_map.sv
module pmem_window_map
    import pmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_bitop,
    output logic [7:0]        bus_rdata,
    output logic              rd_valid,
    output logic              window_uninit,
    output logic              illegal_write,
    output logic [11:0]       pm_addr,
    output logic              pm_rd,
    input  logic [7:0]        pm_rdata,
    output logic [7:0]        ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              ram_rd,
    output logic              ram_wr,
    input  logic [7:0]        ram_rdata
);
    logic              in_win, is_page, is_plain;
    logic              page_we, written;
    logic [PAGE_W-1:0] page;
    logic              any_wr, refused;
    rd_state_t         state, state_nx;

    pmw_decode u_dec (
        .addr    (bus_addr),
        .in_win  (in_win),
        .is_page (is_page),
        .is_plain(is_plain)
    );

    assign page_we = bus_wr && is_page;

    pmw_page_reg u_page (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (page_we),
        .wdata  (bus_wdata[PAGE_W-1:0]),
        .page   (page),
        .written(written)
    );

    assign any_wr    = bus_wr || bus_bitop;
    assign refused   = (any_wr && in_win) || (bus_bitop && is_page) || (bus_rd && is_page);
    assign pm_addr   = {page, bus_addr[OFF_W-1:0]};
    assign pm_rd     = bus_rd && in_win;
    assign ram_addr  = bus_addr;
    assign ram_wdata = bus_wdata;
    assign ram_rd    = bus_rd && is_plain;
    assign ram_wr    = any_wr && is_plain;

    always_comb begin
        if (!bus_rd)      state_nx = S_IDLE;
        else if (in_win)  state_nx = S_WIN;
        else if (is_page) state_nx = S_LOCK;
        else              state_nx = S_RAM;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= S_IDLE;
            illegal_write <= 1'b0;
            window_uninit <= 1'b0;
        end else begin
            state         <= state_nx;
            illegal_write <= refused;
            window_uninit <= pm_rd && !written;
        end
    end

    always_comb begin
        rd_valid  = 1'b1;
        bus_rdata = '0;
        unique case (state)
            S_IDLE: rd_valid  = 1'b0;
            S_WIN:  bus_rdata = pm_rdata;
            S_RAM:  bus_rdata = ram_rdata;
            S_LOCK: bus_rdata = LOCK_DATA;
            default: rd_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/pmem_window_map_chk.sv
module pmem_window_map_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic        bus_bitop,
    input logic [7:0]  bus_rdata,
    input logic        rd_valid,
    input logic        illegal_write,
    input logic        ram_rd,
    input logic        ram_wr,
    input logic        pm_rd,
    input logic [5:0]  page,
    input logic        written
);
    logic win_a;
    assign win_a = (bus_addr[7:6] == 2'b01);

    AST_RD_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> rd_valid);                                            // R1
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !rd_valid);                                          // R9
    AST_WIN_READ_PM: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && win_a) |-> (pm_rd && !ram_rd));                       // R1
    AST_LOCK_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 8'hC9) |=> (bus_rdata == 8'hFF && illegal_write)); // R4
    AST_WIN_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_bitop) && win_a) |-> !ram_wr);                   // R6
    AST_WIN_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_bitop) && win_a) |=> illegal_write);             // R6
    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (written && !(bus_wr && bus_addr == 8'hC9)) |=> $stable(page));  // R5
endmodule

bind pmem_window_map pmem_window_map_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_bitop    (bus_bitop),
    .bus_rdata    (bus_rdata),
    .rd_valid     (rd_valid),
    .illegal_write(illegal_write),
    .ram_rd       (ram_rd),
    .ram_wr       (ram_wr),
    .pm_rd        (pm_rd),
    .page         (page),
    .written      (written)
);

// File: tb/pmem_window_map_test.sv
module pmem_window_map_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0, bus_wdata = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_bitop = 1'b0;
    logic [7:0]  bus_rdata;
    logic        rd_valid, window_uninit, illegal_write;
    logic [11:0] pm_addr;
    logic        pm_rd;
    logic [7:0]  pm_rdata = '0;
    logic [7:0]  ram_addr, ram_wdata;
    logic        ram_rd, ram_wr;
    logic [7:0]  ram_rdata = '0;
    logic [7:0]  ram_mem [256];

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmem_window_map uut (.*);

    function automatic logic [7:0] rom_val(input logic [11:0] a);
        return 8'(a * 12'd37) ^ a[11:4] ^ 8'h5A;
    endfunction

    always_ff @(posedge clk) begin
        if (pm_rd) pm_rdata <= rom_val(pm_addr);
        if (ram_wr) ram_mem[ram_addr] <= ram_wdata;
        if (ram_rd) ram_rdata <= ram_mem[ram_addr];
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one strobe cycle; returns at the next falling edge, where results are visible
    task automatic access(input logic rd, input logic wr, input logic bt,
                          input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_rd = rd; bus_wr = wr; bus_bitop = bt;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_bitop = 1'b0;
    endtask

    task automatic t_reset;
        chk("R10 rd_valid", 16'(rd_valid), 16'h0);
        chk("R10 illegal", 16'(illegal_write), 16'h0);
        chk("R10 uninit", 16'(window_uninit), 16'h0);
    endtask

    task automatic t_uninit;
        access(1, 0, 0, 8'h45, 8'h00);
        chk("R8 uninit high", 16'(window_uninit), 16'h1);
        chk("R1 valid", 16'(rd_valid), 16'h1);
    endtask

    task automatic t_example_a19;
        access(0, 1, 0, 8'hC9, 8'hE8); // 0x28 with bits 7:6 set
        @(negedge clk);
        bus_addr = 8'h59; bus_rd = 1'b1;
        #1;
        chk("R2 pm_addr A19", 16'(pm_addr), 16'h0A19);
        chk("R1 pm_rd", 16'(pm_rd), 16'h1);
        chk("R1 ram idle", 16'(ram_rd), 16'h0);
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R3 R2 data A19", 16'(bus_rdata), 16'(rom_val(12'hA19)));
        chk("R1 valid", 16'(rd_valid), 16'h1);
        chk("R8 uninit low", 16'(window_uninit), 16'h0);
    endtask

    task automatic t_corners;
        access(0, 1, 0, 8'hC9, 8'h00);
        access(1, 0, 0, 8'h40, 8'h00);
        chk("R2 data 000", 16'(bus_rdata), 16'(rom_val(12'h000)));
        access(0, 1, 0, 8'hC9, 8'h3F);
        access(1, 0, 0, 8'h7F, 8'h00);
        chk("R2 data FFF", 16'(bus_rdata), 16'(rom_val(12'hFFF)));
        // back-to-back reads across the window
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 8'h41;
        @(negedge clk);
        chk("R1 b2b first", 16'(bus_rdata), 16'(rom_val(12'hFC1)));
        bus_addr = 8'h62;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R1 b2b second", 16'(bus_rdata), 16'(rom_val(12'hFE2)));
    endtask

    task automatic t_lock_read;
        access(0, 1, 0, 8'hC9, 8'h12);
        access(1, 0, 0, 8'hC9, 8'h00);
        chk("R4 reads FF", 16'(bus_rdata), 16'h00FF);
        chk("R4 valid", 16'(rd_valid), 16'h1);
        chk("R4 illegal pulse", 16'(illegal_write), 16'h1);
        @(negedge clk);
        chk("R4 pulse one cycle", 16'(illegal_write), 16'h0);
        access(1, 0, 0, 8'h43, 8'h00);
        chk("R4 page kept", 16'(bus_rdata), 16'(rom_val({6'h12, 6'h03})));
    endtask

    task automatic t_bitop_page;
        access(0, 0, 1, 8'hC9, 8'h13);
        chk("R5 illegal pulse", 16'(illegal_write), 16'h1);
        access(1, 0, 0, 8'h44, 8'h00);
        chk("R5 page unchanged", 16'(bus_rdata), 16'(rom_val({6'h12, 6'h04})));
    endtask

    task automatic t_win_write;
        access(0, 1, 0, 8'h10, 8'h77);
        @(negedge clk);
        bus_addr = 8'h50; bus_wdata = 8'h33; bus_wr = 1'b1;
        #1;
        chk("R6 no ram_wr", 16'(ram_wr), 16'h0);
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R6 illegal pulse", 16'(illegal_write), 16'h1);
        access(0, 0, 1, 8'h7E, 8'h01);
        chk("R6 bitop pulse", 16'(illegal_write), 16'h1);
        access(1, 0, 0, 8'h50, 8'h00);
        chk("R6 window intact", 16'(bus_rdata), 16'(rom_val({6'h12, 6'h10})));
        chk("R6 no pulse on read", 16'(illegal_write), 16'h0);
    endtask

    task automatic t_ram;
        access(0, 1, 0, 8'h10, 8'hA5);
        access(0, 0, 1, 8'hD0, 8'h5C);
        @(negedge clk);
        bus_addr = 8'h10; bus_rd = 1'b1;
        #1;
        chk("R9 ram_rd", 16'(ram_rd), 16'h1);
        chk("R9 ram_addr", 16'(ram_addr), 16'h0010);
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R9 ram data", 16'(bus_rdata), 16'h00A5);
        chk("R9 valid", 16'(rd_valid), 16'h1);
        access(1, 0, 0, 8'hD0, 8'h00);
        chk("R11 bitop to ram", 16'(bus_rdata), 16'h005C);
        chk("R11 no flag", 16'(illegal_write), 16'h0);
    endtask

    task automatic t_reset_keeps;
        access(0, 1, 0, 8'hC9, 8'h15);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        t_reset();
        access(1, 0, 0, 8'h43, 8'h00);
        chk("R7 page survives", 16'(bus_rdata), 16'(rom_val({6'h15, 6'h03})));
        chk("R8 flag after reset", 16'(window_uninit), 16'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_uninit();
        t_example_a19();
        t_corners();
        t_lock_read();
        t_bitop_page();
        t_win_write();
        t_ram();
        t_reset_keeps();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule